// File: doc/BRIEF.md
# Sense-Before-Write Access Controller

This block sequences every host access to an 8-bit-wide resistive crosspoint memory macro. The host side offers write, read and forming requests with an address and a data word. The macro side drives the line-bias decoder with an operating mode, a word address and two per-bit programming masks, pulses the sense-amplifier enable, and takes back the sensed word.

Writes never program blindly. Each write first senses the addressed word. The sensed value is compared with the new data, and only the bits that must change get a programming pulse: a set mask for bits going to one and a reset mask for bits going to zero. When nothing differs, the write phase is skipped altogether. This avoids repeated set pulses on cells that already hold the right value. A counter of bit positions that were not programmed is brought out for test.

Reads hold the decoder in read bias until the bitline signal has developed, pulse the sense enable for one cycle, and latch the comparator word into the data-out register. Forming initialises a fresh word in two phases: the upper resistor first, then the lower one. Each phase has its own mode code and a programmable length.

Top module: `sbw_access_ctrl`

## Requirements
- R1: A write request first holds `beMode` at READ (code 1) and pulses `senseEn` for exactly one cycle before any cycle with `beMode` at WRITE (code 2). After the operation, the stored word equals the new data.
- R2: During the write phase, `wrOneMask` has a bit set exactly where the new data is 1 and the sensed word is 0. `wrZeroMask` has a bit set exactly where the new data is 0 and the sensed word is 1. All other bits are left unprogrammed.
- R3: Both masks are zero whenever `beMode` is not WRITE. If the sensed word equals the new data, no WRITE cycle occurs, and the write still completes.
- R4: A read keeps `beMode` at READ for DEV_CYC cycles with `senseEn` low, then for one cycle with `senseEn` high. `hostDout` then shows the sensed word and keeps it until the next read, including across writes and forming.
- R5: Each write adds to `skipCount` the number of bit positions it did not program (DW minus the number of differing bits).
- R6: A forming request drives `beMode` to FORM_TOP (code 3) for FORM_CYC cycles, then to FORM_BOT (code 4) for FORM_CYC cycles, and programs no mask bits.
- R7: `busy` is high from the cycle after a request is accepted until completion. Completion is a one-cycle `done` pulse with `busy` low. Requests presented while `busy` is high are ignored.
- R8: When several requests are raised together, write wins over read, and read wins over forming. `hostWe` and `hostRe` together therefore perform a write.
- R9: After reset, `busy`, `done` and `senseEn` are low, `beMode` is IDLE (code 0), both masks are zero, and `hostDout` and `skipCount` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWe | input | 1 | Write request |
| hostRe | input | 1 | Read request |
| hostForm | input | 1 | Forming request |
| hostAddr | input | AW | Word address of the request |
| hostDin | input | DW | New data for a write |
| hostDout | output | DW | Last word read |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| beMode | output | 3 | Decoder mode: 0 idle, 1 read, 2 write, 3 form top, 4 form bottom |
| beAddr | output | AW | Word address to the decoder |
| wrOneMask | output | DW | Bits to set to one in this cycle |
| wrZeroMask | output | DW | Bits to reset to zero in this cycle |
| senseEn | output | 1 | Sense-amplifier enable |
| senseData | input | DW | Sensed word from the comparators |
| skipCount | output | CW | Running count of bit positions not programmed |

## Verification
The assertions assume that the macro returns a defined word on `senseData` for the current `beAddr` whenever `senseEn` is high. They also assume that a programmed bit takes its new value by the next clock edge, so a write phase always starts from a freshly sensed, differing word. The bench supplies a behavioural array that answers `senseData` from its contents without delay and applies the two masks at each write-cycle edge, which keeps both assumptions true. Host requests are driven on the falling edge and held for one cycle only, except where a request is raised on purpose during a busy operation to show that it is dropped.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

  typedef enum logic [2:0] {
    MODE_IDLE     = 3'd0,
    MODE_READ     = 3'd1,
    MODE_WRITE    = 3'd2,
    MODE_FORM_TOP = 3'd3,
    MODE_FORM_BOT = 3'd4
  } beMode_e;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_READ  = 2'd1,
    OP_FORM  = 2'd2
  } hostOp_e;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic latchReq;     // capture address and data of an accepted request
    logic captureRead;  // load sensed word into the data-out register
    logic captureDiff;  // build programming masks from sensed word
    logic driveWrite;   // present masks to the decoder
  } dpStrobe_t;

endpackage

// File: rtl/sbw_ctrl.sv
module sbw_ctrl
  import sbw_pkg::*;
#(
  parameter int DEV_CYC  = 1,
  parameter int WR_CYC   = 1,
  parameter int FORM_CYC = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      hostWe,
  input  logic      hostRe,
  input  logic      hostForm,
  input  logic      noFlip,
  output logic      busy,
  output logic      done,
  output beMode_e   mode,
  output logic      senseEn,
  output dpStrobe_t strobe
);

  localparam int MAX_A = (FORM_CYC > DEV_CYC) ? FORM_CYC : DEV_CYC;
  localparam int MAX_C = (MAX_A > WR_CYC) ? MAX_A : WR_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_DEV, S_SENSE, S_WRITE, S_FTOP, S_FBOT, S_FIN
  } state_e;

  state_e     state;
  hostOp_e    curOp;
  hostOp_e    reqOp;
  logic [CNT_W-1:0] phaseCnt;
  logic       anyReq;
  logic       accept;

  assign anyReq = hostWe | hostRe | hostForm;
  assign accept = anyReq && (state == S_IDLE || state == S_FIN);

  // write beats read, read beats forming
  always_comb begin
    if (hostWe)      reqOp = OP_WRITE;
    else if (hostRe) reqOp = OP_READ;
    else             reqOp = OP_FORM;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      curOp    <= OP_READ;
      phaseCnt <= '0;
    end else begin
      case (state)
        S_IDLE, S_FIN: begin
          if (accept) begin
            curOp <= reqOp;
            if (reqOp == OP_FORM) begin
              state    <= S_FTOP;
              phaseCnt <= CNT_W'(FORM_CYC - 1);
            end else begin
              state    <= S_DEV;
              phaseCnt <= CNT_W'(DEV_CYC - 1);
            end
          end else begin
            state <= S_IDLE;
          end
        end
        S_DEV: begin
          if (phaseCnt == '0) state <= S_SENSE;
          else                phaseCnt <= phaseCnt - 1'b1;
        end
        S_SENSE: begin
          if (curOp == OP_READ || noFlip) begin
            state <= S_FIN;
          end else begin
            state    <= S_WRITE;
            phaseCnt <= CNT_W'(WR_CYC - 1);
          end
        end
        S_WRITE: begin
          if (phaseCnt == '0) state <= S_FIN;
          else                phaseCnt <= phaseCnt - 1'b1;
        end
        S_FTOP: begin
          if (phaseCnt == '0) begin
            state    <= S_FBOT;
            phaseCnt <= CNT_W'(FORM_CYC - 1);
          end else begin
            phaseCnt <= phaseCnt - 1'b1;
          end
        end
        S_FBOT: begin
          if (phaseCnt == '0) state <= S_FIN;
          else                phaseCnt <= phaseCnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    busy    = !(state == S_IDLE || state == S_FIN);
    done    = (state == S_FIN);
    senseEn = (state == S_SENSE);
    case (state)
      S_DEV, S_SENSE: mode = MODE_READ;
      S_WRITE:        mode = MODE_WRITE;
      S_FTOP:         mode = MODE_FORM_TOP;
      S_FBOT:         mode = MODE_FORM_BOT;
      default:        mode = MODE_IDLE;
    endcase
    strobe.latchReq    = accept;
    strobe.captureRead = (state == S_SENSE) && (curOp == OP_READ);
    strobe.captureDiff = (state == S_SENSE) && (curOp == OP_WRITE);
    strobe.driveWrite  = (state == S_WRITE);
  end

endmodule

// File: rtl/sbw_datapath.sv
module sbw_datapath
  import sbw_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strobe,
  input  logic [AW-1:0] hostAddr,
  input  logic [DW-1:0] hostDin,
  input  logic [DW-1:0] senseData,
  output logic [AW-1:0] beAddr,
  output logic [DW-1:0] wrOneMask,
  output logic [DW-1:0] wrZeroMask,
  output logic [DW-1:0] hostDout,
  output logic [CW-1:0] skipCount,
  output logic          noFlip
);

  logic [AW-1:0] addrReg;
  logic [DW-1:0] dinReg;
  logic [DW-1:0] doutReg;
  logic [DW-1:0] oneReg;
  logic [DW-1:0] zeroReg;
  logic [DW-1:0] setNext;
  logic [DW-1:0] resetNext;
  logic [CW-1:0] skipReg;

  // per-bit programming decision
  for (genvar b = 0; b < DW; b++) begin : g_bitDecide
    assign setNext[b]   =  dinReg[b] & ~senseData[b];
    assign resetNext[b] = ~dinReg[b] &  senseData[b];
  end

  assign noFlip = ((setNext | resetNext) == '0);

  function automatic logic [CW-1:0] untouchedBits(input logic [DW-1:0] flips);
    logic [CW-1:0] n;
    n = '0;
    for (int i = 0; i < DW; i++) begin
      if (!flips[i]) n = n + 1'b1;
    end
    return n;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      dinReg  <= '0;
      doutReg <= '0;
      oneReg  <= '0;
      zeroReg <= '0;
      skipReg <= '0;
    end else begin
      if (strobe.latchReq) begin
        addrReg <= hostAddr;
        dinReg  <= hostDin;
      end
      if (strobe.captureRead) doutReg <= senseData;
      if (strobe.captureDiff) begin
        oneReg  <= setNext;
        zeroReg <= resetNext;
        skipReg <= skipReg + untouchedBits(setNext | resetNext);
      end
    end
  end

  assign beAddr     = addrReg;
  assign hostDout   = doutReg;
  assign skipCount  = skipReg;
  assign wrOneMask  = strobe.driveWrite ? oneReg  : '0;
  assign wrZeroMask = strobe.driveWrite ? zeroReg : '0;

endmodule

// File: rtl/sbw_access_ctrl.sv
module sbw_access_ctrl
  import sbw_pkg::*;
#(
  parameter int AW       = 6,
  parameter int DW       = 8,
  parameter int CW       = 16,
  parameter int DEV_CYC  = 1,
  parameter int WR_CYC   = 1,
  parameter int FORM_CYC = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          hostWe,
  input  logic          hostRe,
  input  logic          hostForm,
  input  logic [AW-1:0] hostAddr,
  input  logic [DW-1:0] hostDin,
  output logic [DW-1:0] hostDout,
  output logic          busy,
  output logic          done,
  output logic [2:0]    beMode,
  output logic [AW-1:0] beAddr,
  output logic [DW-1:0] wrOneMask,
  output logic [DW-1:0] wrZeroMask,
  output logic          senseEn,
  input  logic [DW-1:0] senseData,
  output logic [CW-1:0] skipCount
);

  dpStrobe_t strobe;
  beMode_e   modeInt;
  logic      noFlip;

  sbw_ctrl #(
    .DEV_CYC (DEV_CYC),
    .WR_CYC  (WR_CYC),
    .FORM_CYC(FORM_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .hostWe  (hostWe),
    .hostRe  (hostRe),
    .hostForm(hostForm),
    .noFlip  (noFlip),
    .busy    (busy),
    .done    (done),
    .mode    (modeInt),
    .senseEn (senseEn),
    .strobe  (strobe)
  );

  sbw_datapath #(
    .AW(AW),
    .DW(DW),
    .CW(CW)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .hostAddr  (hostAddr),
    .hostDin   (hostDin),
    .senseData (senseData),
    .beAddr    (beAddr),
    .wrOneMask (wrOneMask),
    .wrZeroMask(wrZeroMask),
    .hostDout  (hostDout),
    .skipCount (skipCount),
    .noFlip    (noFlip)
  );

  assign beMode = modeInt;

endmodule

// File: rtl/sbw_access_ctrl_chk.sv
module sbw_access_ctrl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          busy,
  input logic          done,
  input logic [2:0]    beMode,
  input logic [DW-1:0] wrOneMask,
  input logic [DW-1:0] wrZeroMask,
  input logic          senseEn
);

  // R1: a write phase is entered only straight after a sense pulse
  p_sense_first_r1: assert property (@(posedge clk) disable iff (!rstN)
    (beMode == 3'd2 && $past(beMode) != 3'd2) |-> $past(senseEn));

  // R3: masks stay quiet outside the write phase
  p_mask_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    (beMode != 3'd2) |-> (wrOneMask == '0 && wrZeroMask == '0));

  // R3: a write phase always programs at least one bit
  p_write_nonempty_r3: assert property (@(posedge clk) disable iff (!rstN)
    (beMode == 3'd2) |-> ((wrOneMask | wrZeroMask) != '0));

  // R4: sense enable is a single-cycle pulse under read bias
  p_sense_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    senseEn |=> !senseEn);

  // R4: sense enable only after at least one cycle of read bias
  p_sense_settled_r4: assert property (@(posedge clk) disable iff (!rstN)
    senseEn |-> (beMode == 3'd1 && $past(beMode) == 3'd1));

  // R6: the bottom forming phase follows the top one
  p_form_order_r6: assert property (@(posedge clk) disable iff (!rstN)
    (beMode == 3'd4 && $past(beMode) != 3'd4) |-> ($past(beMode) == 3'd3));

  // R7: completion pulse lasts one cycle with busy released
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy ##1 !done));

endmodule

bind sbw_access_ctrl sbw_access_ctrl_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busy      (busy),
  .done      (done),
  .beMode    (beMode),
  .wrOneMask (wrOneMask),
  .wrZeroMask(wrZeroMask),
  .senseEn   (senseEn)
);

// File: tb/sbw_access_ctrl_bench.sv
`timescale 1ns/1ps
module sbw_access_ctrl_bench;

  localparam int AW = 6;
  localparam int DW = 8;
  localparam int CW = 16;
  localparam int FC = 4;
  localparam int NV = 10;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          hostWe = 1'b0, hostRe = 1'b0, hostForm = 1'b0;
  logic [AW-1:0] hostAddr = '0;
  logic [DW-1:0] hostDin = '0;
  logic [DW-1:0] hostDout;
  logic          busy, done, senseEn;
  logic [2:0]    beMode;
  logic [AW-1:0] beAddr;
  logic [DW-1:0] wrOneMask, wrZeroMask, senseData;
  logic [CW-1:0] skipCount;

  always #2.5 clk = ~clk;

  sbw_access_ctrl #(.AW(AW), .DW(DW), .CW(CW), .DEV_CYC(1), .WR_CYC(1), .FORM_CYC(FC))
  u_sbw_access_ctrl (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostRe(hostRe), .hostForm(hostForm),
    .hostAddr(hostAddr), .hostDin(hostDin), .hostDout(hostDout), .busy(busy),
    .done(done), .beMode(beMode), .beAddr(beAddr), .wrOneMask(wrOneMask),
    .wrZeroMask(wrZeroMask), .senseEn(senseEn), .senseData(senseData),
    .skipCount(skipCount)
  );

  // behavioural array
  logic [DW-1:0] mem [1<<AW];
  logic [DW-1:0] shadow [1<<AW];
  initial for (int i = 0; i < (1<<AW); i++) begin mem[i] = '0; shadow[i] = '0; end
  assign senseData = mem[beAddr];
  always @(posedge clk)
    if (beMode == 3'd2) mem[beAddr] <= (mem[beAddr] | wrOneMask) & ~wrZeroMask;

  // activity monitor
  int wrCyc, senseCyc, devCyc, ftopCyc, fbotCyc, doneCnt, orderBad;
  logic [DW-1:0] oneSeen, zeroSeen;
  always @(posedge clk) begin
    if (beMode == 3'd2) begin
      wrCyc++; oneSeen |= wrOneMask; zeroSeen |= wrZeroMask;
    end
    if (senseEn) senseCyc++;
    if (beMode == 3'd1 && !senseEn) devCyc++;
    if (beMode == 3'd3) begin ftopCyc++; if (fbotCyc != 0) orderBad++; end
    if (beMode == 3'd4) fbotCyc++;
    if (done) doneCnt++;
  end

  int nRun = 0, nFail = 0;
  int skipExp = 0;
  logic busySeen;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clearStats();
    wrCyc = 0; senseCyc = 0; devCyc = 0; ftopCyc = 0; fbotCyc = 0;
    doneCnt = 0; orderBad = 0; oneSeen = '0; zeroSeen = '0;
  endtask

  task automatic waitDone();
    for (int t = 0; t < 100; t++) begin
      @(negedge clk);
      if (done) break;
    end
  endtask

  task automatic doOp(input logic we, input logic re, input logic fm,
                      input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    clearStats();
    hostWe = we; hostRe = re; hostForm = fm; hostAddr = a; hostDin = d;
    @(negedge clk);
    hostWe = 0; hostRe = 0; hostForm = 0;
    busySeen = busy;
    waitDone();
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  // {isRead, addr, data, expected read}
  localparam logic [22:0] VEC [NV] = '{
    {1'b0, 6'd1, 8'hA5, 8'h00},
    {1'b1, 6'd1, 8'h00, 8'hA5},
    {1'b0, 6'd1, 8'hA5, 8'h00},
    {1'b0, 6'd1, 8'h5A, 8'h00},
    {1'b1, 6'd1, 8'h00, 8'h5A},
    {1'b0, 6'd2, 8'hFF, 8'h00},
    {1'b1, 6'd2, 8'h00, 8'hFF},
    {1'b0, 6'd2, 8'h00, 8'h00},
    {1'b1, 6'd2, 8'h00, 8'h00},
    {1'b1, 6'd1, 8'h00, 8'h5A}
  };

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual hung expected finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9", "busy", busy, 0);
    chk("R9", "done", done, 0);
    chk("R9", "beMode", beMode, 0);
    chk("R9", "senseEn", senseEn, 0);
    chk("R9", "masks", {wrOneMask, wrZeroMask}, 0);
    chk("R9", "hostDout", hostDout, 0);
    chk("R9", "skipCount", skipCount, 0);

    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      logic [AW-1:0] a;
      logic [DW-1:0] d, prev, diff;
      v = VEC[i]; a = v[21:16]; d = v[15:8];
      if (v[22]) begin
        doOp(0, 1, 0, a, 0);
        chk("R4", "read data", hostDout, v[7:0]);
        chk("R4", "sense pulses", senseCyc, 1);
        chk("R4", "develop cycles", devCyc, 1);
      end else begin
        prev = shadow[a];
        diff = d ^ prev;
        doOp(1, 0, 0, a, d);
        chk("R1", "sense before write", senseCyc, 1);
        chk("R1", "stored word", mem[a], d);
        chk("R2", "set mask", oneSeen, d & ~prev);
        chk("R2", "reset mask", zeroSeen, ~d & prev);
        chk("R3", "write cycles", wrCyc, (diff != 0) ? 1 : 0);
        skipExp += DW - $countones(diff);
        chk("R5", "skip count", skipCount, skipExp);
        chk("R7", "busy during op", busySeen, 1);
        shadow[a] = d;
      end
    end

    // R8: write and read together act as a write; R4: dout held across write
    doOp(1, 1, 0, 6'd3, 8'h3C);
    chk("R8", "we+re stored", mem[3], 8'h3C);
    chk("R8", "we+re write cycles", wrCyc, 1);
    chk("R4", "dout held over write", hostDout, 8'h5A);
    skipExp += DW - $countones(8'h3C);
    doOp(0, 1, 0, 6'd3, 0);
    chk("R4", "read back", hostDout, 8'h3C);

    // R7: request while busy is dropped
    @(negedge clk);
    clearStats();
    hostWe = 1; hostAddr = 6'd4; hostDin = 8'h66;
    @(negedge clk);
    hostWe = 0; hostRe = 1; hostAddr = 6'd1;
    @(negedge clk);
    hostRe = 0;
    waitDone();
    @(negedge clk);
    chk("R7", "done pulses", doneCnt, 1);
    chk("R7", "sense pulses", senseCyc, 1);
    chk("R7", "idle after", busy, 0);
    chk("R7", "done released", done, 0);
    chk("R7", "dout untouched", hostDout, 8'h3C);
    chk("R7", "stored word", mem[4], 8'h66);
    skipExp += DW - $countones(8'h66);
    chk("R5", "skip count", skipCount, skipExp);

    // R6: forming
    doOp(0, 0, 1, 6'd7, 0);
    chk("R6", "top phase", ftopCyc, FC);
    chk("R6", "bottom phase", fbotCyc, FC);
    chk("R6", "order", orderBad, 0);
    chk("R6", "no programming", wrCyc, 0);
    chk("R4", "dout after form", hostDout, 8'h3C);

    finishRun();
  end

endmodule